// File: doc/BRIEF.md
# Bit-Operand Effective-Address Generator

This block forms the byte address that a memory bit operation (clear, set or test of one bit in a byte or halfword) works on. The decoder supplies a mode, a 4-bit register selector, a displacement with its extension kind, and an absolute address. The block drives up to three register-file read indices. It takes the returned data back in the same cycle and registers a 24-bit address together with a valid strobe.

The register file has sixteen entries. Entries 0 to 11 are 16 bits wide and entries 12 to 15 are 32 bits wide. The read data ports are 32 bits wide. For a narrow entry only bits [15:0] carry meaning, and the block ignores whatever the file returns above them. A wide base can be made from two adjacent narrow registers. An indexed form adds one of two 32-bit index registers to a pair that is picked through an irregular numbering. Absolute operands skip all register arithmetic.

Top module: `eag_top`

## Requirements
- R1: After reset, `addr_valid_o` is 0 and `addr_o` is 0 until the first accepted request.
- R2: A request with `req_valid_i`=1 at a rising edge gives `addr_valid_o`=1 with its address after that same edge. `addr_valid_o` is 0 after any edge with no request, and `addr_o` then keeps its previous value.
- R3: Mode 0 (absolute) gives `addr_o` = `abs_addr_i`, whatever the register data and displacement are.
- R4: Mode 1 (16-bit base) uses bits [15:0] of the selected register, zero-extended, plus the displacement. This holds when the register is one of the 32-bit ones, and when the file returns nonzero upper bits.
- R5: Mode 2 (pair base) with selector n below 12 uses the base {r[n+1][15:0], r[n][15:0]}. When n is 11, the upper half comes from bits [15:0] of r12.
- R6: Mode 2 with selector n of 12 or more uses all 32 bits of r[n] as the base.
- R7: Mode 3 (indexed) adds r12 when selector bit 3 is 0 and r13 when it is 1. The index register is read on port C.
- R8: In mode 3, k = selector bits [2:0] picks the pair's low register: 2k when k<6, and (2k+3) mod 16 when k>=6. That gives r15 for k=6 and r1 for k=7. The pair value follows the R5/R6 rule.
- R9: The 20-bit displacement is sign-extended when `disp_signed_i`=1 and zero-extended otherwise. The sum is truncated to its low 24 bits.
- R10: The read indices follow from the inputs combinationally. Port A carries the base or pair-low register in modes 1, 2 and 3. Port B carries A+1 mod 16 in modes 2 and 3. Port C carries the index register in mode 3. Unused ports are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | 0 absolute, 1 16-bit base, 2 pair base, 3 indexed |
| reg_sel_i | input | 4 | Register selector (base register or index/pair code) |
| disp_i | input | 20 | Displacement |
| disp_signed_i | input | 1 | 1: sign-extend displacement, 0: zero-extend |
| abs_addr_i | input | 24 | Absolute address for mode 0 |
| rf_idx_a_o | output | 4 | Read index, port A |
| rf_idx_b_o | output | 4 | Read index, port B |
| rf_idx_c_o | output | 4 | Read index, port C |
| rf_data_a_i | input | 32 | Read data, port A |
| rf_data_b_i | input | 32 | Read data, port B |
| rf_data_c_i | input | 32 | Read data, port C |
| addr_o | output | 24 | Registered effective address |
| addr_valid_o | output | 1 | Registered valid strobe |

## Verification
The read indices have zero latency. The bench samples them 1 ns after it drives a request at a falling edge, well before the capturing rising edge. The address and valid strobe are due one edge later. The bench drives every request at a falling edge and compares at the next falling edge, so exactly one rising edge lies between stimulus and check. Hold behaviour is checked with an idle cycle placed between two requests. The address must not change across that cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    EA_ABS     = 2'd0,
    EA_LOW16   = 2'd1,
    EA_PAIR    = 2'd2,
    EA_INDEXED = 2'd3
  } ea_mode_e;
endpackage

// File: rtl/eag_port_sel.sv
module eag_port_sel
  import eag_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int IDX_LO_R = 12
) (
  input  ea_mode_e         mode_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o,
  output logic [IDX_W-1:0] idx_c_o
);
  localparam logic [IDX_W-1:0] IdxLo = IDX_W'(IDX_LO_R);
  localparam logic [IDX_W-1:0] IdxHi = IDX_W'(IDX_LO_R + 1);

  logic [2:0]       pair_code;
  logic [IDX_W-1:0] pair_low;

  // irregular pair numbering: low regs 0,2,..,10 then 15, then wraps
  always_comb begin
    pair_code = sel_i[2:0];
    if (pair_code < 3'd6) pair_low = IDX_W'({pair_code, 1'b0});
    else                  pair_low = IDX_W'({pair_code, 1'b0}) + IDX_W'(3);
  end

  always_comb begin
    idx_a_o = '0;
    idx_b_o = '0;
    idx_c_o = '0;
    unique case (mode_i)
      EA_LOW16: idx_a_o = sel_i;
      EA_PAIR: begin
        idx_a_o = sel_i;
        idx_b_o = sel_i + IDX_W'(1);
      end
      EA_INDEXED: begin
        idx_a_o = pair_low;
        idx_b_o = pair_low + IDX_W'(1);
        idx_c_o = sel_i[3] ? IdxHi : IdxLo;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_base_form.sv
module eag_base_form
  import eag_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int REG_W    = 32,
  parameter int NARROW_W = 16,
  parameter int N_NARROW = 12
) (
  input  ea_mode_e         mode_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [REG_W-1:0] data_a_i,
  input  logic [REG_W-1:0] data_b_i,
  input  logic [REG_W-1:0] data_c_i,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] index_o
);
  localparam int UPPER_W = REG_W - 2 * NARROW_W;

  logic [REG_W-1:0] low_ext;
  logic [REG_W-1:0] joined;
  logic             a_is_wide;

  generate
    if (UPPER_W > 0) begin : g_pad
      assign joined = {{UPPER_W{1'b0}}, data_b_i[NARROW_W-1:0], data_a_i[NARROW_W-1:0]};
    end else begin : g_nopad
      assign joined = {data_b_i[NARROW_W-1:0], data_a_i[NARROW_W-1:0]};
    end
  endgenerate

  assign low_ext   = {{(REG_W-NARROW_W){1'b0}}, data_a_i[NARROW_W-1:0]};
  assign a_is_wide = (int'(idx_a_i) >= N_NARROW);

  always_comb begin
    base_o  = '0;
    index_o = '0;
    unique case (mode_i)
      EA_LOW16: base_o = low_ext;
      EA_PAIR:  base_o = a_is_wide ? data_a_i : joined;
      EA_INDEXED: begin
        base_o  = a_is_wide ? data_a_i : joined;
        index_o = data_c_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_adder.sv
module eag_adder
  import eag_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DISP_W = 20,
  parameter int ADDR_W = 24
) (
  input  ea_mode_e          mode_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic [REG_W-1:0]  index_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              disp_signed_i,
  input  logic [ADDR_W-1:0] abs_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [REG_W-1:0] disp_ext;
  logic [REG_W-1:0] sum;

  generate
    if (DISP_W < REG_W) begin : g_ext
      assign disp_ext = {{(REG_W-DISP_W){disp_signed_i & disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_noext
      assign disp_ext = disp_i[REG_W-1:0];
    end
  endgenerate

  assign sum = base_i + index_i + disp_ext;

  always_comb begin
    if (mode_i == EA_ABS) addr_o = abs_i;
    else                  addr_o = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DISP_W   = 20,
  parameter int REG_W    = 32,
  parameter int NARROW_W = 16,
  parameter int N_REGS   = 16,
  parameter int N_NARROW = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [1:0]                mode_i,
  input  logic [$clog2(N_REGS)-1:0] reg_sel_i,
  input  logic [DISP_W-1:0]         disp_i,
  input  logic                      disp_signed_i,
  input  logic [ADDR_W-1:0]         abs_addr_i,
  output logic [$clog2(N_REGS)-1:0] rf_idx_a_o,
  output logic [$clog2(N_REGS)-1:0] rf_idx_b_o,
  output logic [$clog2(N_REGS)-1:0] rf_idx_c_o,
  input  logic [REG_W-1:0]          rf_data_a_i,
  input  logic [REG_W-1:0]          rf_data_b_i,
  input  logic [REG_W-1:0]          rf_data_c_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      addr_valid_o
);
  localparam int IDX_W = $clog2(N_REGS);

  ea_mode_e         mode;
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [REG_W-1:0] base;
  logic [REG_W-1:0] index_term;
  logic [ADDR_W-1:0] addr_calc;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              valid_d, valid_q;
  logic              addr_en;

  assign mode = ea_mode_e'(mode_i);

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  eag_port_sel #(.IDX_W(IDX_W), .IDX_LO_R(N_NARROW)) u_port_sel (
    .mode_i (mode),
    .sel_i  (reg_sel_i),
    .idx_a_o(rf_idx_a_o),
    .idx_b_o(rf_idx_b_o),
    .idx_c_o(rf_idx_c_o)
  );

  eag_base_form #(
    .IDX_W(IDX_W), .REG_W(REG_W), .NARROW_W(NARROW_W), .N_NARROW(N_NARROW)
  ) u_base_form (
    .mode_i  (mode),
    .idx_a_i (rf_idx_a_o),
    .data_a_i(rf_data_a_i),
    .data_b_i(rf_data_b_i),
    .data_c_i(rf_data_c_i),
    .base_o  (base),
    .index_o (index_term)
  );

  eag_adder #(.REG_W(REG_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_adder (
    .mode_i       (mode),
    .base_i       (base),
    .index_i      (index_term),
    .disp_i       (disp_i),
    .disp_signed_i(disp_signed_i),
    .abs_i        (abs_addr_i),
    .addr_o       (addr_calc)
  );

  // next state
  always_comb begin
    addr_en = req_valid_i;
    valid_d = req_valid_i;
    addr_d  = addr_q;
    if (addr_en) addr_d = addr_calc;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        mode_i,
  input logic [IDX_W-1:0]  reg_sel_i,
  input logic [ADDR_W-1:0] abs_addr_i,
  input logic [IDX_W-1:0]  rf_idx_a_o,
  input logic [IDX_W-1:0]  rf_idx_b_o,
  input logic [IDX_W-1:0]  rf_idx_c_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_valid_o
);
  a_r2_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_valid_o);

  a_r2_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !addr_valid_o);

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(addr_o));

  a_r3_abs_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd0) |=> addr_o == $past(abs_addr_i));

  a_r7_index_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> rf_idx_c_o == (reg_sel_i[3] ? IDX_W'(13) : IDX_W'(12)));

  a_r8_low_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && reg_sel_i[2:0] < 3'd6) |-> rf_idx_a_o == IDX_W'({reg_sel_i[2:0], 1'b0}));

  a_r10_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1]) |-> rf_idx_b_o == rf_idx_a_o + IDX_W'(1));
endmodule

bind eag_top eag_checker #(.ADDR_W(ADDR_W), .IDX_W($clog2(N_REGS))) u_eag_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .req_valid_i (req_valid_i),
  .mode_i      (mode_i),
  .reg_sel_i   (reg_sel_i),
  .abs_addr_i  (abs_addr_i),
  .rf_idx_a_o  (rf_idx_a_o),
  .rf_idx_b_o  (rf_idx_b_o),
  .rf_idx_c_o  (rf_idx_c_o),
  .addr_o      (addr_o),
  .addr_valid_o(addr_valid_o)
);

// File: tb/eag_top_tb_top.sv
`timescale 1ns/1ps
module eag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  mode;
  logic [3:0]  reg_sel;
  logic [19:0] disp;
  logic        disp_signed;
  logic [23:0] abs_addr;
  logic [3:0]  idx_a, idx_b, idx_c;
  logic [31:0] data_a, data_b, data_c;
  logic [23:0] addr;
  logic        addr_valid;

  logic [31:0] rf [16];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  assign data_a = rf[idx_a];
  assign data_b = rf[idx_b];
  assign data_c = rf[idx_c];

  eag_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .mode_i(mode),
    .reg_sel_i(reg_sel), .disp_i(disp), .disp_signed_i(disp_signed),
    .abs_addr_i(abs_addr), .rf_idx_a_o(idx_a), .rf_idx_b_o(idx_b),
    .rf_idx_c_o(idx_c), .rf_data_a_i(data_a), .rf_data_b_i(data_b),
    .rf_data_c_i(data_c), .addr_o(addr), .addr_valid_o(addr_valid)
  );

  function automatic logic [31:0] f_ext(logic [19:0] d, logic s);
    return s ? {{12{d[19]}}, d} : {12'h000, d};
  endfunction

  function automatic logic [31:0] f_pair(logic [3:0] n);
    if (n >= 4'd12) return rf[n];
    return {rf[n + 4'd1][15:0], rf[n][15:0]};
  endfunction

  function automatic logic [3:0] f_low(logic [2:0] k);
    if (k < 3'd6) return {k, 1'b0};
    return {k, 1'b0} + 4'd3;
  endfunction

  function automatic logic [23:0] f_addr(logic [1:0] m, logic [3:0] s,
                                         logic [19:0] d, logic sg, logic [23:0] ab);
    logic [31:0] t;
    case (m)
      2'd0:    return ab;
      2'd1:    t = {16'h0, rf[s][15:0]} + f_ext(d, sg);
      2'd2:    t = f_pair(s) + f_ext(d, sg);
      default: t = rf[s[3] ? 4'd13 : 4'd12] + f_pair(f_low(s[2:0])) + f_ext(d, sg);
    endcase
    return t[23:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_rf();
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
  endtask

  // drive at falling edge, check ports now and address one edge later
  task automatic apply(string req, logic [1:0] m, logic [3:0] s,
                       logic [19:0] d, logic sg, logic [23:0] ab);
    logic [23:0] exp;
    logic [3:0]  ea, eb, ec;
    @(negedge clk);
    req_valid = 1'b1; mode = m; reg_sel = s; disp = d;
    disp_signed = sg; abs_addr = ab;
    exp = f_addr(m, s, d, sg, ab);
    ea = 4'd0; eb = 4'd0; ec = 4'd0;
    case (m)
      2'd1: ea = s;
      2'd2: begin ea = s; eb = s + 4'd1; end
      2'd3: begin ea = f_low(s[2:0]); eb = ea + 4'd1; ec = s[3] ? 4'd13 : 4'd12; end
      default: ;
    endcase
    #1;
    check("R10 port A", 32'(idx_a), 32'(ea));
    check("R10 port B", 32'(idx_b), 32'(eb));
    check("R10 port C", 32'(idx_c), 32'(ec));
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(addr_valid), 32'd1);
    check(req, 32'(addr), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; req_valid = 1'b0; mode = 2'd0; reg_sel = 4'd0;
    disp = '0; disp_signed = 1'b0; abs_addr = '0;
    fill_rf();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid after reset", 32'(addr_valid), 32'd0);
    check("R1 addr after reset", 32'(addr), 32'd0);

    // R3: absolute ignores registers and displacement
    apply("R3 abs", 2'd0, 4'd5, 20'hFFFFF, 1'b1, 24'hABCDEF);
    // R4: 32-bit register used as 16-bit base, upper bits dropped
    rf[14] = 32'hDEAD_1234;
    apply("R4 low16 wide reg", 2'd1, 4'd14, 20'h00010, 1'b0, 24'h0);
    rf[3] = 32'hFFFF_FFF0;
    apply("R4 low16 narrow reg upper garbage", 2'd1, 4'd3, 20'h00005, 1'b0, 24'h0);
    // R5: pair across r11/r12
    rf[11] = 32'h5555_0002; rf[12] = 32'h0000_0001;
    apply("R5 pair n=11", 2'd2, 4'd11, 20'h00000, 1'b0, 24'h0);
    apply("R5 pair n=0", 2'd2, 4'd0, 20'h00100, 1'b0, 24'h0);
    // R6: wide register direct
    rf[15] = 32'h0012_3456;
    apply("R6 pair wide n=15", 2'd2, 4'd15, 20'h00001, 1'b0, 24'h0);
    // R7/R8: index r12 and r13, k=6 -> r15, k=7 -> r1
    apply("R7 index r12 k=2", 2'd3, 4'd2, 20'h00010, 1'b0, 24'h0);
    apply("R7 index r13 k=6", 2'd3, 4'd14, 20'h00000, 1'b0, 24'h0);
    apply("R8 k=7 wrap", 2'd3, 4'd7, 20'h00003, 1'b0, 24'h0);
    // R9: same field, signed vs unsigned, and 24-bit wrap
    rf[4] = 32'h0000_0010;
    apply("R9 signed neg disp", 2'd1, 4'd4, 20'hFFFF0, 1'b1, 24'h0);
    apply("R9 unsigned disp", 2'd1, 4'd4, 20'hFFFF0, 1'b0, 24'h0);
    rf[12] = 32'h00FF_FFFF;
    apply("R9 truncate", 2'd2, 4'd12, 20'h00002, 1'b0, 24'h0);

    // R2: idle cycle keeps address, drops valid
    held = addr;
    @(negedge clk);
    check("R2 idle valid", 32'(addr_valid), 32'd0);
    check("R2 idle hold", 32'(addr), 32'(held));

    for (int v = 0; v < 400; v++) begin
      if (v % 25 == 0) fill_rf();
      apply("R4-R9 random", 2'($urandom), 4'($urandom), 20'($urandom),
            1'($urandom), 24'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule